// File: doc/BRIEF.md
# Position Frame Serializer with Inverted CRC

This block forms the data part of one serial position frame for a sensor slave. It captures a multi-turn period count, an angle word and two error flags on a start strobe. It then puts them out one bit per enabled cycle on a single data line. A cyclic check value over all count, angle and error bits follows the data. The check value is sent complemented, and an optional zero bit can close the frame.

The surrounding line logic owns clock recovery, acknowledge and start bits, and timeouts. It asserts `shift_en` in each cycle where the next bit may be consumed. The configuration picks how many counter bits are sent and whether the angle is sent at full or reduced resolution. It also picks whether the wider check value is forced, and whether the trailing zero bit is left out. The check width follows the frame length automatically unless it is forced.

Top module: `pos_frame_serializer`

## Requirements
- R1: After reset `busy` and `frame_done` are 0 and `sdo` is 1; `sdo` stays 1 whenever no frame is in progress.
- R2: A `start` pulse while idle captures all data and configuration inputs and begins a frame in the next cycle; `start` while a frame is running is ignored.
- R3: The frame carries the counter field, then the angle field, then the two error bits (bit 1 first), each field MSB first. One bit advances per cycle with `shift_en` high, and `sdo` and `busy` hold unchanged while `shift_en` is low.
- R4: `cfg_cnt_len` values 0, 1, 2, 3 send 0, 8, 16, 24 counter bits, taken from the low bits of `cnt_in`.
- R5: With `cfg_res_low` = 0 all 13 angle bits are sent; with `cfg_res_low` = 1 only the 12 upper bits `ang_in[12:1]` are sent.
- R6: The 5-bit check uses x^5+x^2+1 with a zero start value over all counter, angle and error bits, and it is sent complemented, MSB first.
- R7: The 6-bit check uses x^6+x+1 and is chosen when counter plus angle plus error bits exceed 25, or when `cfg_crc6_force` = 1.
- R8: A single 0 bit follows the check bits when `cfg_no_zero` = 0; with `cfg_no_zero` = 1 the frame ends after the check bits.
- R9: `frame_done` pulses for exactly one cycle, the cycle after the last bit was shifted, and `busy` drops in that same cycle.
- R10: Changes on any data or configuration input during a frame do not alter the bits of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start strobe |
| shift_en | input | 1 | Consume current bit and advance |
| cfg_cnt_len | input | 2 | Counter length select (0/8/16/24 bits) |
| cfg_res_low | input | 1 | Reduced angle resolution (12 bits) |
| cfg_crc6_force | input | 1 | Force the 6-bit check |
| cfg_no_zero | input | 1 | Omit the trailing zero bit |
| cnt_in | input | 3*CNT_STEP | Period counter value |
| ang_in | input | ANG_W | Angle value |
| err_in | input | 2 | Error flags |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with its defaults: 8-bit counter steps, a 13-bit angle and an automatic switch above 25 bits. With these values, frames of 14 to 39 data bits are reachable. Both sides of the automatic check-width switch come up (14, 15, 22 and 23 bits against 30, 31, 38 and 39), along with the forced wide case on a short frame. Random enable gaps and inputs that change in mid-frame cover stalls, ignored starts, and a new start in the same cycle as the end pulse.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_CRC,
        PH_ZERO
    } phase_e;

    typedef struct packed {
        logic [1:0] cnt_len;
        logic       res_low;
        logic       crc6_force;
        logic       no_zero;
    } frame_cfg_t;

    localparam int CRC_MAX_W = 6;
    localparam logic [CRC_MAX_W-1:0] POLY5_TAPS = 6'h05;
    localparam logic [CRC_MAX_W-1:0] POLY6_TAPS = 6'h03;

    // One MSB-first Galois step; in narrow mode bit 5 is kept clear.
    function automatic logic [CRC_MAX_W-1:0] crc_step(
        input logic [CRC_MAX_W-1:0] cur,
        input logic                 din,
        input logic                 wide
    );
        logic                 fb;
        logic [CRC_MAX_W-1:0] nx;
        fb = din ^ (wide ? cur[5] : cur[4]);
        nx = {cur[4:0], 1'b0};
        if (!wide) nx[5] = 1'b0;
        if (fb) nx = nx ^ (wide ? POLY6_TAPS : POLY5_TAPS);
        return nx;
    endfunction

endpackage

// File: rtl/pfs_field_pack.sv
module pfs_field_pack
    import pfs_pkg::*;
#(
    parameter int CNT_STEP   = 8,
    parameter int ANG_W      = 13,
    parameter int AUTO_LIMIT = 25,
    parameter int DATA_W     = 3 * CNT_STEP + ANG_W + 2,
    parameter int LEN_W      = $clog2(DATA_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    shift,
    input  frame_cfg_t              cfg_in,
    input  logic [3*CNT_STEP-1:0]   cnt_in,
    input  logic [ANG_W-1:0]        ang_in,
    input  logic [1:0]              err_in,
    output logic                    data_msb,
    output logic [LEN_W-1:0]        data_len,
    output logic                    crc_wide,
    output logic                    no_zero
);
    localparam int CNT_MAX_W = 3 * CNT_STEP;
    localparam int TAIL_W    = ANG_W + 2;

    logic [LEN_W-1:0]     n_cnt;
    logic [LEN_W-1:0]     n_ang;
    logic [LEN_W-1:0]     len_d;
    logic [CNT_MAX_W-1:0] cnt_al;
    logic [TAIL_W-1:0]    tail_v;
    logic [DATA_W-1:0]    vec_d;
    logic                 wide_d;

    logic [DATA_W-1:0]    vec_q;
    logic [LEN_W-1:0]     len_q;
    logic                 wide_q;
    logic                 nz_q;

    // R4 / R5: field widths from configuration, left-aligned assembly
    always_comb begin
        n_cnt  = LEN_W'(cfg_in.cnt_len) * LEN_W'(CNT_STEP);
        n_ang  = cfg_in.res_low ? LEN_W'(ANG_W - 1) : LEN_W'(ANG_W);
        len_d  = n_cnt + n_ang + LEN_W'(2);
        cnt_al = cnt_in << (LEN_W'(CNT_MAX_W) - n_cnt);
        tail_v = cfg_in.res_low ? {ang_in[ANG_W-1:1], err_in, 1'b0}
                                : {ang_in, err_in};
        vec_d  = {cnt_al, {TAIL_W{1'b0}}}
               | ({tail_v, {CNT_MAX_W{1'b0}}} >> n_cnt);
        wide_d = cfg_in.crc6_force || (len_d > LEN_W'(AUTO_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= '0;
            len_q  <= LEN_W'(ANG_W + 2);
            wide_q <= 1'b0;
            nz_q   <= 1'b0;
        end else if (load) begin
            vec_q  <= vec_d;
            len_q  <= len_d;
            wide_q <= wide_d;
            nz_q   <= cfg_in.no_zero;
        end else if (shift) begin
            vec_q  <= {vec_q[DATA_W-2:0], 1'b0};
        end
    end

    assign data_msb = vec_q[DATA_W-1];
    assign data_len = len_q;
    assign crc_wide = wide_q;
    assign no_zero  = nz_q;

    // R10: captured frame content only moves on load or shift
    a_r10_capture_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> ($stable(vec_q) && $stable(len_q) && $stable(wide_q)));

    // R4: captured length always within the legal range
    a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
        (len_q >= LEN_W'(ANG_W + 1)) && (len_q <= LEN_W'(DATA_W)));

endmodule

// File: rtl/pfs_crc.sv
module pfs_crc
    import pfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic data_shift,
    input  logic data_bit,
    input  logic out_shift,
    input  logic wide,
    output logic crc_out_inv
);
    logic [CRC_MAX_W-1:0] crc_q;
    logic [CRC_MAX_W-1:0] crc_d;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = '0;
        end else if (data_shift) begin
            crc_d = crc_step(crc_q, data_bit, wide);
        end else if (out_shift) begin
            crc_d = {crc_q[4:0], 1'b0};
            if (!wide) crc_d[5] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= '0;
        else     crc_q <= crc_d;
    end

    // R6: complemented MSB of the active width
    assign crc_out_inv = ~(wide ? crc_q[5] : crc_q[4]);

    // R6: narrow mode never carries a sixth bit
    a_r6_narrow_clear: assert property (@(posedge clk) disable iff (rst)
        (!wide && !$past(wide)) |-> (crc_q[5] == 1'b0));

    // R6: each frame starts from a zero register
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (crc_q == '0));

endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
    import pfs_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             shift_en,
    input  logic [LEN_W-1:0] data_len,
    input  logic             crc_wide,
    input  logic             no_zero,
    output phase_e           phase,
    output logic             load,
    output logic             shift_data,
    output logic             shift_crc,
    output logic             frame_done
);
    phase_e           ph_q, ph_d;
    logic [LEN_W-1:0] bit_q, bit_d;
    logic             done_q, done_d;
    logic             last_data;
    logic             last_crc;

    assign last_data  = (bit_q == data_len - LEN_W'(1));
    assign last_crc   = (bit_q == (crc_wide ? LEN_W'(5) : LEN_W'(4)));
    assign load       = (ph_q == PH_IDLE) && start;
    assign shift_data = (ph_q == PH_DATA) && shift_en;
    assign shift_crc  = (ph_q == PH_CRC) && shift_en;

    always_comb begin
        ph_d   = ph_q;
        bit_d  = bit_q;
        done_d = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_d  = PH_DATA;
                    bit_d = '0;
                end
            end
            PH_DATA: begin
                if (shift_en) begin
                    if (last_data) begin
                        ph_d  = PH_CRC;
                        bit_d = '0;
                    end else begin
                        bit_d = bit_q + LEN_W'(1);
                    end
                end
            end
            PH_CRC: begin
                if (shift_en) begin
                    if (last_crc) begin
                        bit_d = '0;
                        if (no_zero) begin
                            ph_d   = PH_IDLE;
                            done_d = 1'b1;
                        end else begin
                            ph_d = PH_ZERO;
                        end
                    end else begin
                        bit_d = bit_q + LEN_W'(1);
                    end
                end
            end
            PH_ZERO: begin
                if (shift_en) begin
                    ph_d   = PH_IDLE;
                    done_d = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            bit_q  <= '0;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            bit_q  <= bit_d;
            done_q <= done_d;
        end
    end

    assign phase      = ph_q;
    assign frame_done = done_q;

    // R9: end pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R2: a running frame is never reloaded
    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE && start && !shift_en) |=> (ph_q == $past(ph_q)));

endmodule

// File: rtl/pos_frame_serializer.sv
module pos_frame_serializer
    import pfs_pkg::*;
#(
    parameter int CNT_STEP   = 8,
    parameter int ANG_W      = 13,
    parameter int AUTO_LIMIT = 25
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  shift_en,
    input  logic [1:0]            cfg_cnt_len,
    input  logic                  cfg_res_low,
    input  logic                  cfg_crc6_force,
    input  logic                  cfg_no_zero,
    input  logic [3*CNT_STEP-1:0] cnt_in,
    input  logic [ANG_W-1:0]      ang_in,
    input  logic [1:0]            err_in,
    output logic                  sdo,
    output logic                  busy,
    output logic                  frame_done
);
    localparam int DATA_W = 3 * CNT_STEP + ANG_W + 2;
    localparam int LEN_W  = $clog2(DATA_W + 1);

    frame_cfg_t       cfg;
    phase_e           phase;
    logic             load;
    logic             shift_data;
    logic             shift_crc;
    logic             data_msb;
    logic [LEN_W-1:0] data_len;
    logic             crc_wide;
    logic             no_zero;
    logic             crc_bit_inv;

    assign cfg = '{cnt_len:    cfg_cnt_len,
                   res_low:    cfg_res_low,
                   crc6_force: cfg_crc6_force,
                   no_zero:    cfg_no_zero};

    pfs_field_pack #(
        .CNT_STEP   (CNT_STEP),
        .ANG_W      (ANG_W),
        .AUTO_LIMIT (AUTO_LIMIT),
        .DATA_W     (DATA_W),
        .LEN_W      (LEN_W)
    ) u_pack (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift_data),
        .cfg_in   (cfg),
        .cnt_in   (cnt_in),
        .ang_in   (ang_in),
        .err_in   (err_in),
        .data_msb (data_msb),
        .data_len (data_len),
        .crc_wide (crc_wide),
        .no_zero  (no_zero)
    );

    pfs_crc u_crc (
        .clk         (clk),
        .rst         (rst),
        .clear       (load),
        .data_shift  (shift_data),
        .data_bit    (data_msb),
        .out_shift   (shift_crc),
        .wide        (crc_wide),
        .crc_out_inv (crc_bit_inv)
    );

    pfs_seq #(
        .LEN_W (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .shift_en   (shift_en),
        .data_len   (data_len),
        .crc_wide   (crc_wide),
        .no_zero    (no_zero),
        .phase      (phase),
        .load       (load),
        .shift_data (shift_data),
        .shift_crc  (shift_crc),
        .frame_done (frame_done)
    );

    always_comb begin
        unique case (phase)
            PH_DATA: sdo = data_msb;
            PH_CRC:  sdo = crc_bit_inv;
            PH_ZERO: sdo = 1'b0;
            default: sdo = 1'b1;
        endcase
    end

    assign busy = (phase != PH_IDLE);

    // R1: idle line is high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sdo);

    // R3: a stall freezes the line
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !shift_en) |=> (busy && $stable(sdo)));

    // R8: trailing bit is low
    a_r8_zero_low: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ZERO) |-> !sdo);

    // R9: busy only falls together with the end pulse
    a_r9_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> frame_done);

endmodule

// File: tb/sim_pos_frame_serializer.sv
module sim_pos_frame_serializer;
    localparam int CNT_STEP = 8;
    localparam int ANG_W    = 13;
    localparam int CNT_W    = 3 * CNT_STEP;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             shift_en = 1'b0;
    logic [1:0]       cfg_cnt_len = 2'd0;
    logic             cfg_res_low = 1'b0;
    logic             cfg_crc6_force = 1'b0;
    logic             cfg_no_zero = 1'b0;
    logic [CNT_W-1:0] cnt_in = '0;
    logic [ANG_W-1:0] ang_in = '0;
    logic [1:0]       err_in = '0;
    logic             sdo;
    logic             busy;
    logic             frame_done;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    bit    m_busy = 1'b0;
    bit    m_done = 1'b0;
    bit    q[$];

    always #5 clk = ~clk;

    pos_frame_serializer #(.CNT_STEP(CNT_STEP), .ANG_W(ANG_W), .AUTO_LIMIT(25)) u0 (
        .clk(clk), .rst(rst), .start(start), .shift_en(shift_en),
        .cfg_cnt_len(cfg_cnt_len), .cfg_res_low(cfg_res_low),
        .cfg_crc6_force(cfg_crc6_force), .cfg_no_zero(cfg_no_zero),
        .cnt_in(cnt_in), .ang_in(ang_in), .err_in(err_in),
        .sdo(sdo), .busy(busy), .frame_done(frame_done)
    );

    // Expected bit list from the requirements (R3..R8), check by long division
    task automatic build_frame();
        bit msg[$];
        int n_cnt, w, poly, rem;
        n_cnt = 8 * int'(cfg_cnt_len);
        q.delete();
        for (int i = n_cnt - 1; i >= 0; i--) msg.push_back(cnt_in[i]);
        for (int i = ANG_W - 1; i >= (cfg_res_low ? 1 : 0); i--) msg.push_back(ang_in[i]);
        msg.push_back(err_in[1]);
        msg.push_back(err_in[0]);
        w    = (cfg_crc6_force || msg.size() > 25) ? 6 : 5;
        poly = (w == 6) ? 'h43 : 'h25;
        rem  = 0;
        for (int i = 0; i < msg.size() + w; i++) begin
            rem = (rem << 1) | ((i < msg.size()) ? int'(msg[i]) : 0);
            if (((rem >> w) & 1) != 0) rem = rem ^ poly;
        end
        foreach (msg[i]) q.push_back(msg[i]);
        for (int i = w - 1; i >= 0; i--) q.push_back(((rem >> i) & 1) == 0);
        if (!cfg_no_zero) q.push_back(1'b0);
    endtask

    task automatic compare(input string tag);
        bit e_sdo;
        e_sdo = m_busy ? q[0] : 1'b1;
        checks++;
        if (sdo !== e_sdo || busy !== m_busy || frame_done !== m_done) begin
            errors++;
            $display("FAIL %s: sdo=%b busy=%b done=%b expected sdo=%b busy=%b done=%b",
                     tag, sdo, busy, frame_done, e_sdo, m_busy, m_done);
        end
    endtask

    task automatic step(input bit st, input bit sh, input string tag);
        start    = st;
        shift_en = sh;
        @(posedge clk);
        m_done = 1'b0;
        if (!m_busy && st) begin
            build_frame();
            m_busy = 1'b1;
        end else if (m_busy && sh) begin
            void'(q.pop_front());
            if (q.size() == 0) begin
                m_busy = 1'b0;
                m_done = 1'b1;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic scramble_inputs();
        cnt_in         = CNT_W'($urandom);
        ang_in         = ANG_W'($urandom);
        err_in         = 2'($urandom);
        cfg_cnt_len    = 2'($urandom);
        cfg_res_low    = 1'($urandom);
        cfg_crc6_force = 1'($urandom);
        cfg_no_zero    = 1'($urandom);
    endtask

    // R2 / R10: inputs scrambled and start pulsed at random during the frame
    task automatic run_frame(input bit [1:0] cl, input bit res, input bit frc,
                             input bit nz, input bit stall, input bit back2back,
                             input string tag);
        int guard;
        cnt_in         = CNT_W'($urandom);
        ang_in         = ANG_W'($urandom);
        err_in         = 2'($urandom);
        cfg_cnt_len    = cl;
        cfg_res_low    = res;
        cfg_crc6_force = frc;
        cfg_no_zero    = nz;
        step(1'b1, 1'b1, tag);
        guard = 0;
        while (m_busy && guard < 500) begin
            scramble_inputs();
            step(1'($urandom), stall ? 1'($urandom) : 1'b1, tag);
            guard++;
        end
        if (!back2back) step(1'b0, 1'b0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst = 1'b0;
        step(1'b0, 1'b1, "R1 idle");

        run_frame(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 8-bit count, R6 CRC5, R8 zero");
        run_frame(2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 auto CRC6, 24-bit count");
        run_frame(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 forced CRC6, R5 12-bit angle");
        run_frame(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 16-bit count");
        run_frame(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 no count CRC5");
        run_frame(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 reduced angle");
        run_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 stalls");
        run_frame(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10 mid-frame changes");
        run_frame(2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 back to back");
        run_frame(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 start in done cycle");
        for (int k = 0; k < 40; k++) begin
            run_frame(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), "R3 random frame");
        end
        step(1'b0, 1'b0, "R9 final idle");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule